// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is the boundary data register that sits between a TAP controller and the I/O ring of a small device. It holds 97 serial cells in a fixed layout. Three kinds of cell guard the 21 bidirectional pins: one observes the pad, one holds output data and one holds an enable override. One cell observes a dedicated input-only pin. The remaining cells are internal placeholders with no pin behind them. Serial data enters at the end farthest from the test data output and moves one cell toward it on each shift strobe.

The TAP controller supplies capture, shift and update strobes, all of them clock enables on the test clock. It also supplies an external-test mode level and a force-high-impedance level. While the mode is low, the core's output data and enables pass straight to the pads. While it is high, the update latches of the output and control cells drive the pads. The force input overrides both cases and disables every output driver. The control latches reset to the disabling value, so entering external test without a preload never drives a pin.

Top module: `bsr_chain`

## Requirements
- R1: The chain is exactly 97 cells long. A bit presented on `tdi` with a shift strobe appears on `tdo` after exactly 96 further shift strobes, and bits come out in the order they went in.
- R2: On a capture strobe, each cell loads a value by kind. Pad-observe cells load `pad_in` of their pin. Output cells load `core_out`. Control cells load the inverse of `core_oe`. Cell 0 loads `aux_in`. Internal cells load 0.
- R3: `tdo` always shows cell 0. A shift strobe moves every cell one place toward cell 0, and `tdi` enters cell 96. With no capture or shift strobe, the chain and `tdo` hold.
- R4: The pad drive values seen in external-test mode change only after an update strobe. Shifting or capturing alone leaves `pad_out` and `pad_oe` unchanged.
- R5: With `extest_mode`=1 and `force_highz`=0, `pad_out[p]` equals the latched output cell of pin p. `pad_oe[p]` is the inverse of the latched control cell of pin p, so a control value of 1 means high impedance.
- R6: With `extest_mode`=0 and `force_highz`=0, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`.
- R7: After reset, every shift cell holds 0, every output latch holds 0 and every control latch holds 1. In external-test mode with no update since reset, `pad_oe` is all zeros.
- R8: `force_highz`=1 makes `pad_oe` all zeros in either mode.
- R9: Cell layout, with cell 0 nearest `tdo`. Cells 1-9, 22-33, 61-69 and 88-90 are internal. Pin triplets fill 10-21, 34-60, 70-87 and 91-96. Pins are numbered 0 to 20 in order of rising cell index. Pin p's triplet starting at cell n holds the control cell at n, the output cell at n+1 and the observe cell at n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test logic reset |
| tdi | input | 1 | Serial data into cell 96 |
| capture_en | input | 1 | Capture strobe: parallel load of the chain |
| shift_en | input | 1 | Shift strobe: move the chain one cell toward `tdo` |
| update_en | input | 1 | Update strobe: copy output and control cells into their latches |
| extest_mode | input | 1 | Pads are driven from the update latches when high |
| force_highz | input | 1 | Disables every output driver |
| aux_in | input | 1 | Dedicated input-only pin observed by cell 0 |
| core_out | input | 21 | Core output data per pin |
| core_oe | input | 21 | Core output enable per pin, 1 = drive |
| pad_in | input | 21 | Value seen at each pad |
| pad_out | output | 21 | Data toward each pad driver |
| pad_oe | output | 21 | Enable toward each pad driver, 1 = drive |
| tdo | output | 1 | Serial data out of cell 0 |

## Verification
The properties assume that the TAP controller raises at most one of the capture, shift and update strobes in any cycle. The stimulus raises them strictly one at a time. The hold properties also assume that `extest_mode` and `force_highz` are steady while the chain shifts. The stimulus changes these levels only between scan operations, in cycles with no strobe. The bench holds the strobes idle through reset and for a few cycles after release, which covers the reset synchronizer's delay.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [2:0] {
    CK_AUX,
    CK_INT,
    CK_CTL,
    CK_OUT,
    CK_IN
  } cell_kind_e;

  localparam int unsigned CHAIN_LEN = 97;
  localparam int unsigned SEG_N     = 4;
  localparam int unsigned TRIPLET   = 3;

  // first cell of each pin segment, counted from the tdo end
  function automatic int unsigned seg_lo(int unsigned s);
    case (s)
      0:       return 10;
      1:       return 34;
      2:       return 70;
      default: return 91;
    endcase
  endfunction

  // last cell of each pin segment
  function automatic int unsigned seg_hi(int unsigned s);
    case (s)
      0:       return 21;
      1:       return 60;
      2:       return 87;
      default: return 96;
    endcase
  endfunction

  // number of pins that lie in segments below s
  function automatic int unsigned seg_pin_base(int unsigned s);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < s; k++) begin
      acc += (seg_hi(k) - seg_lo(k) + 1) / TRIPLET;
    end
    return acc;
  endfunction

  localparam int unsigned PIN_COUNT = seg_pin_base(SEG_N);

  function automatic cell_kind_e kind_of(int unsigned idx);
    cell_kind_e k;
    k = CK_INT;
    if (idx == 0) k = CK_AUX;
    for (int unsigned s = 0; s < SEG_N; s++) begin
      if (idx >= seg_lo(s) && idx <= seg_hi(s)) begin
        case ((idx - seg_lo(s)) % TRIPLET)
          0:       k = CK_CTL;
          1:       k = CK_OUT;
          default: k = CK_IN;
        endcase
      end
    end
    return k;
  endfunction

  function automatic int unsigned pin_of(int unsigned idx);
    int unsigned p;
    p = 0;
    for (int unsigned s = 0; s < SEG_N; s++) begin
      if (idx >= seg_lo(s) && idx <= seg_hi(s)) begin
        p = seg_pin_base(s) + (idx - seg_lo(s)) / TRIPLET;
      end
    end
    return p;
  endfunction

endpackage

// File: rtl/bsr_rst_sync.sv
module bsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/bsr_obs_cell.sv
module bsr_obs_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic cap_d,
  input  logic ser_d,
  output logic q
);

  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (cap_en) begin
      q_nxt = cap_d;
    end else if (shift_en) begin
      q_nxt = ser_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/bsr_upd_cell.sv
module bsr_upd_cell #(
  parameter logic UPD_RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic cap_d,
  input  logic ser_d,
  output logic q,
  output logic upd_q
);

  logic q_nxt;
  logic upd_nxt;

  always_comb begin
    q_nxt = q;
    if (cap_en) begin
      q_nxt = cap_d;
    end else if (shift_en) begin
      q_nxt = ser_d;
    end
  end

  always_comb begin
    upd_nxt = upd_q;
    if (upd_en) begin
      upd_nxt = q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= UPD_RST;
    end else begin
      upd_q <= upd_nxt;
    end
  end

endmodule

// File: rtl/bsr_pin_drive.sv
module bsr_pin_drive (
  input  logic mode,
  input  logic hiz,
  input  logic core_d,
  input  logic core_en,
  input  logic upd_d,
  input  logic upd_ctl,
  output logic pad_d,
  output logic pad_en
);

  always_comb begin
    pad_d  = mode ? upd_d : core_d;
    pad_en = mode ? ~upd_ctl : core_en;
    if (hiz) begin
      pad_en = 1'b0;
    end
  end

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain #(
  parameter int unsigned CELLS = bsr_pkg::CHAIN_LEN,
  parameter int unsigned PINS  = bsr_pkg::PIN_COUNT
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            capture_en,
  input  logic            shift_en,
  input  logic            update_en,
  input  logic            extest_mode,
  input  logic            force_highz,
  input  logic            aux_in,
  input  logic [PINS-1:0] core_out,
  input  logic [PINS-1:0] core_oe,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic            tdo
);

  import bsr_pkg::*;

  localparam int unsigned LAST = CELLS - 1;

  logic             rst_n_int;
  logic [CELLS-1:0] shift_q;
  logic [PINS-1:0]  upd_data;
  logic [PINS-1:0]  upd_ctl;

  bsr_rst_sync #(.STAGES(2)) u_rst (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_n_int)
  );

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    localparam cell_kind_e  KIND = kind_of(i);
    localparam int unsigned PIN  = pin_of(i);
    logic ser_in;

    if (i == LAST) begin : g_head
      assign ser_in = tdi;
    end else begin : g_link
      assign ser_in = shift_q[i+1];
    end

    if (KIND == CK_AUX) begin : g_aux
      bsr_obs_cell u_cell (
        .clk(tck), .rst_n(rst_n_int), .cap_en(capture_en), .shift_en(shift_en),
        .cap_d(aux_in), .ser_d(ser_in), .q(shift_q[i])
      );
    end else if (KIND == CK_INT) begin : g_int
      bsr_obs_cell u_cell (
        .clk(tck), .rst_n(rst_n_int), .cap_en(capture_en), .shift_en(shift_en),
        .cap_d(1'b0), .ser_d(ser_in), .q(shift_q[i])
      );
    end else if (KIND == CK_IN) begin : g_in
      bsr_obs_cell u_cell (
        .clk(tck), .rst_n(rst_n_int), .cap_en(capture_en), .shift_en(shift_en),
        .cap_d(pad_in[PIN]), .ser_d(ser_in), .q(shift_q[i])
      );
    end else if (KIND == CK_OUT) begin : g_out
      bsr_upd_cell #(.UPD_RST(1'b0)) u_cell (
        .clk(tck), .rst_n(rst_n_int), .cap_en(capture_en), .shift_en(shift_en),
        .upd_en(update_en), .cap_d(core_out[PIN]), .ser_d(ser_in),
        .q(shift_q[i]), .upd_q(upd_data[PIN])
      );
    end else begin : g_ctl
      bsr_upd_cell #(.UPD_RST(1'b1)) u_cell (
        .clk(tck), .rst_n(rst_n_int), .cap_en(capture_en), .shift_en(shift_en),
        .upd_en(update_en), .cap_d(~core_oe[PIN]), .ser_d(ser_in),
        .q(shift_q[i]), .upd_q(upd_ctl[PIN])
      );
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    bsr_pin_drive u_drv (
      .mode    (extest_mode),
      .hiz     (force_highz),
      .core_d  (core_out[p]),
      .core_en (core_oe[p]),
      .upd_d   (upd_data[p]),
      .upd_ctl (upd_ctl[p]),
      .pad_d   (pad_out[p]),
      .pad_en  (pad_oe[p])
    );
  end

  assign tdo = shift_q[0];

endmodule

// File: rtl/bsr_chain_checker.sv
module bsr_chain_checker #(
  parameter int unsigned PINS = 21
) (
  input logic            tck,
  input logic            trst_n,
  input logic            capture_en,
  input logic            shift_en,
  input logic            update_en,
  input logic            extest_mode,
  input logic            force_highz,
  input logic [PINS-1:0] core_out,
  input logic [PINS-1:0] core_oe,
  input logic [PINS-1:0] pad_out,
  input logic [PINS-1:0] pad_oe,
  input logic            tdo
);

  logic armed;
  logic upd_seen;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      armed    <= 1'b0;
      upd_seen <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (update_en) upd_seen <= 1'b1;
    end
  end

  // input assumption behind R2/R3/R4: one strobe at a time
  p_strobe_onehot_r2: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({capture_en, shift_en, update_en}));

  p_tdo_hold_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (armed && !$past(shift_en) && !$past(capture_en)) |-> $stable(tdo));

  p_pad_hold_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (armed && extest_mode && $past(extest_mode) && !$past(update_en) && $stable(force_highz))
      |-> ($stable(pad_out) && $stable(pad_oe)));

  p_core_pass_r6: assert property (@(posedge tck) disable iff (!trst_n)
    (!extest_mode && !force_highz) |-> (pad_out == core_out && pad_oe == core_oe));

  p_safe_start_r7: assert property (@(posedge tck) disable iff (!trst_n)
    (extest_mode && !upd_seen) |-> (pad_oe == '0));

  p_force_off_r8: assert property (@(posedge tck) disable iff (!trst_n)
    force_highz |-> (pad_oe == '0));

endmodule

bind bsr_chain bsr_chain_checker #(.PINS(PINS)) u_chk (
  .tck         (tck),
  .trst_n      (trst_n),
  .capture_en  (capture_en),
  .shift_en    (shift_en),
  .update_en   (update_en),
  .extest_mode (extest_mode),
  .force_highz (force_highz),
  .core_out    (core_out),
  .core_oe     (core_oe),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .tdo         (tdo)
);

// File: tb/tb_bsr_chain.sv
module tb_bsr_chain;

  localparam int N = 97;
  localparam int P = 21;

  logic         tck = 1'b0;
  logic         trst_n, tdi, capture_en, shift_en, update_en;
  logic         extest_mode, force_highz, aux_in;
  logic [P-1:0] core_out, core_oe, pad_in;
  logic [P-1:0] pad_out, pad_oe;
  logic         tdo;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R7";

  // cell roles: 0 aux, 1 internal, 2 control, 3 output, 4 observe
  int role_t[N];
  int pin_t[N];
  int out_cell[P];
  int ctl_cell[P];

  // behavioural model state
  bit m_sh[N];
  bit m_uo[P];
  bit m_uc[P];

  bsr_chain dut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .extest_mode(extest_mode),
    .force_highz(force_highz), .aux_in(aux_in), .core_out(core_out),
    .core_oe(core_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .tdo(tdo)
  );

  always #5 tck = ~tck;

  function automatic bit is_internal(int i);
    return (i >= 1 && i <= 9) || (i >= 22 && i <= 33) ||
           (i >= 61 && i <= 69) || (i >= 88 && i <= 90);
  endfunction

  initial begin
    int cnt;
    cnt = 0;
    for (int i = 0; i < N; i++) begin
      pin_t[i] = 0;
      if (i == 0) role_t[i] = 0;
      else if (is_internal(i)) role_t[i] = 1;
      else begin
        role_t[i] = 2 + (cnt % 3);
        pin_t[i]  = cnt / 3;
        if (cnt % 3 == 0) ctl_cell[cnt/3] = i;
        if (cnt % 3 == 1) out_cell[cnt/3] = i;
        cnt++;
      end
    end
  end

  function automatic bit cap_value(int i);
    case (role_t[i])
      0:       return aux_in;
      1:       return 1'b0;
      2:       return ~core_oe[pin_t[i]];
      3:       return core_out[pin_t[i]];
      default: return pad_in[pin_t[i]];
    endcase
  endfunction

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      foreach (m_sh[i]) m_sh[i] = 1'b0;
      foreach (m_uo[p]) begin m_uo[p] = 1'b0; m_uc[p] = 1'b1; end
    end else begin
      bit old[N];
      old = m_sh;
      if (capture_en) begin
        for (int i = 0; i < N; i++) m_sh[i] = cap_value(i);
      end else if (shift_en) begin
        for (int i = 0; i < N-1; i++) m_sh[i] = old[i+1];
        m_sh[N-1] = tdi;
      end
      if (update_en) begin
        for (int p = 0; p < P; p++) begin
          m_uo[p] = old[out_cell[p]];
          m_uc[p] = old[ctl_cell[p]];
        end
      end
    end
  end

  task automatic check_bit(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic check_vec(string req, logic [P-1:0] act, logic [P-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_model();
    logic [P-1:0] e_out, e_oe;
    for (int p = 0; p < P; p++) begin
      e_out[p] = extest_mode ? m_uo[p] : core_out[p];
      e_oe[p]  = force_highz ? 1'b0 : (extest_mode ? ~m_uc[p] : core_oe[p]);
    end
    check_bit(cur_req, tdo, m_sh[0], "tdo");
    check_vec(cur_req, pad_out, e_out, "pad_out");
    check_vec(cur_req, pad_oe, e_oe, "pad_oe");
  endtask

  task automatic tick();
    @(posedge tck);
    @(negedge tck);
    compare_model();
  endtask

  task automatic idle();
    capture_en = 1'b0; shift_en = 1'b0; update_en = 1'b0;
  endtask

  // capture, then shift the whole chain out and compare against the layout
  task automatic capture_and_scan(string req);
    bit got[N];
    int bad;
    capture_en = 1'b1; tick(); capture_en = 1'b0;
    shift_en = 1'b1; tdi = 1'b0;
    for (int k = 0; k < N; k++) begin
      got[k] = tdo;
      tick();
    end
    shift_en = 1'b0;
    bad = 0;
    for (int k = 0; k < N; k++) if (got[k] != cap_value(k)) bad++;
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s capture layout: actual=%0d mismatching cells expected=0", req, bad);
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge tck);
      wd++;
      if (wd > 50000) begin
        errors++;
        $display("FAIL watchdog: actual=%0d cycles expected=<50000", wd);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    bit sent[N];
    bit vec[N];
    bit got[N];
    int bad;
    logic [P-1:0] hold_out, hold_oe;

    trst_n = 1'b0; tdi = 1'b0; idle();
    extest_mode = 1'b0; force_highz = 1'b0; aux_in = 1'b0;
    core_out = '0; core_oe = '0; pad_in = '0;

    // R7: reset state
    cur_req = "R7";
    repeat (3) tick();
    trst_n = 1'b1;
    repeat (4) tick();
    extest_mode = 1'b1;
    tick();
    check_vec("R7", pad_oe, '0, "pad_oe after reset in external test");
    check_bit("R7", tdo, 1'b0, "tdo after reset");
    extest_mode = 1'b0;

    // R6: core pass-through
    cur_req = "R6";
    for (int k = 0; k < 6; k++) begin
      core_out = P'($urandom); core_oe = P'($urandom);
      tick();
    end
    check_vec("R6", pad_out, core_out, "pad_out pass-through");
    check_vec("R6", pad_oe, core_oe, "pad_oe pass-through");

    // R2/R9: capture with two distinct patterns
    cur_req = "R2";
    pad_in = P'($urandom); core_out = P'($urandom); core_oe = P'($urandom); aux_in = 1'b1;
    capture_and_scan("R2");
    cur_req = "R9";
    pad_in = ~pad_in; core_out = P'($urandom); core_oe = ~core_oe; aux_in = 1'b0;
    capture_and_scan("R9");

    // R1/R3: length and ordering
    cur_req = "R1";
    shift_en = 1'b1;
    for (int k = 0; k < N; k++) begin
      sent[k] = 1'($urandom);
      tdi = sent[k];
      tick();
    end
    tdi = 1'b0;
    for (int k = 0; k < N; k++) begin
      got[k] = tdo;
      tick();
    end
    shift_en = 1'b0;
    bad = 0;
    for (int k = 0; k < N; k++) if (got[k] != sent[k]) bad++;
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R1 chain order: actual=%0d mismatches expected=0", bad);
    end
    cur_req = "R3";
    repeat (3) tick();
    check_bit("R3", tdo, 1'b0, "tdo holds without strobes");

    // R4/R5: preload, then update in external test
    cur_req = "R4";
    for (int i = 0; i < N; i++) vec[i] = 1'($urandom);
    shift_en = 1'b1;
    for (int k = 0; k < N; k++) begin
      tdi = vec[k];
      tick();
    end
    shift_en = 1'b0;
    extest_mode = 1'b1;
    repeat (2) tick();
    check_vec("R4", pad_oe, '0, "pad_oe before update");
    cur_req = "R5";
    update_en = 1'b1; tick(); update_en = 1'b0;
    tick();
    bad = 0;
    for (int p = 0; p < P; p++) begin
      if (pad_out[p] !== vec[out_cell[p]]) bad++;
      if (pad_oe[p] !== ~vec[ctl_cell[p]]) bad++;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R5 latched drive: actual=%0d mismatches expected=0", bad);
    end
    cur_req = "R4";
    hold_out = pad_out; hold_oe = pad_oe;
    shift_en = 1'b1;
    for (int k = 0; k < 30; k++) begin
      tdi = 1'($urandom);
      tick();
    end
    shift_en = 1'b0;
    capture_en = 1'b1; tick(); capture_en = 1'b0;
    tick();
    check_vec("R4", pad_out, hold_out, "pad_out held while scanning");
    check_vec("R4", pad_oe, hold_oe, "pad_oe held while scanning");

    // R8: force high impedance in both modes
    cur_req = "R8";
    force_highz = 1'b1;
    tick();
    check_vec("R8", pad_oe, '0, "pad_oe forced off in external test");
    extest_mode = 1'b0; core_oe = '1;
    tick();
    check_vec("R8", pad_oe, '0, "pad_oe forced off in normal mode");
    force_highz = 1'b0;
    tick();

    // R7: reset in the middle of a run
    cur_req = "R7";
    trst_n = 1'b0;
    tick();
    trst_n = 1'b1;
    repeat (3) tick();
    extest_mode = 1'b1;
    tick();
    check_vec("R7", pad_oe, '0, "pad_oe after mid-run reset");
    check_vec("R7", pad_out, '0, "pad_out after mid-run reset");
    extest_mode = 1'b0;
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule